// File: doc/BRIEF.md
# Multi-Rail Power Sequencing Supervisor

This block brings up a set of supply rails in a fixed order and then watches them. It takes one already-synchronized "rail is above its undervoltage point" flag per rail. Bit 0 is the primary rail; bit k is rail k+1. It drives one enable per downstream regulator, plus a power-good output.

During power-up the enables form a chain. The first enable waits until the primary rail has been steady for a hold time. Each later enable follows its own rail flag, provided the enable before it is already on. Power-good asserts once every rail flag and every enable has been high for a second hold time. Both hold times are counted in clock cycles.

When power-good first asserts, the block latches into supervision mode and the enables stop following their flags. In supervision mode, losing the primary rail shuts everything down and restarts the full sequence. Losing a downstream rail only withdraws power-good. Power-good returns after every rail is back and the hold time has passed again.

Top module: `rail_seq_supervisor`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, that edge clears `reg_en`, `pwr_good` and `mode_sup`. `mode_sup` = 0 means power-up mode and 1 means supervision mode.
- R2: If `rail_ok[0]` is low at a rising edge, every bit of `reg_en` and `pwr_good` is low after that edge, in either mode.
- R3: In power-up mode, `reg_en[0]` goes high at the HOLD_CYCLES-th consecutive rising edge at which `rail_ok[0]` is sampled high. If `rail_ok[0]` is low at any edge, the count restarts.
- R4: In power-up mode, for k >= 1, `reg_en[k]` after an edge equals `rail_ok[0]`, the previous `reg_en[k-1]` and `rail_ok[k]` ANDed together. It therefore follows its own flag, both when the flag rises and when it falls.
- R5: In power-up mode, the power-good qualifier is "all `rail_ok` bits high and all `reg_en` bits high". `pwr_good` goes high at the HOLD_CYCLES-th consecutive edge at which this qualifier holds, and `mode_sup` becomes 1 at the same edge. If the qualifier fails at any edge, the count restarts.
- R6: In supervision mode, an edge with `rail_ok[0]` low clears all enables, `pwr_good` and `mode_sup` together, even if other flags change in the same cycle. The full sequence then reruns, including the first hold time.
- R7: In supervision mode, with `rail_ok[0]` high, an edge at which any of `rail_ok[NUM_RAILS-1:1]` is low clears `pwr_good`. At that edge, all enables stay high and `mode_sup` stays 1.
- R8: In supervision mode, `pwr_good` reasserts at the HOLD_CYCLES-th consecutive edge at which all `rail_ok` bits are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rail_ok | input | NUM_RAILS | Per-rail undervoltage-OK flag; bit 0 is the primary rail |
| reg_en | output | NUM_RAILS-1 | Regulator enables; bit k turns on the rail watched by `rail_ok[k+1]` |
| pwr_good | output | 1 | System power-good |
| mode_sup | output | 1 | 0 = power-up mode, 1 = supervision mode |

## Verification
Two pairs of functions can fall in the same cycle.

- In supervision mode, a primary-rail fault and a downstream-rail fault can occur together. The bench drops `rail_ok[0]` and `rail_ok[3]` on the same edge. It then expects the primary-fault reaction (all enables off, back to power-up mode) rather than the milder power-good-only reaction.
- The power-good hold count can expire in the very cycle that its qualifier fails. The bench drops the last rail flag exactly one edge before expiry, and separately inside the supervision recovery window. Each time it expects the count to restart.

In every case the outputs are judged edge by edge against a behavioural reference model.

// File: rtl/rail_seq_pkg.sv
// Package: shared types for the rail sequencing supervisor.
// Assumes: two latched operating modes, encoded in one bit.
package rail_seq_pkg;

    typedef enum logic {
        MODE_POWERUP   = 1'b0,
        MODE_SUPERVISE = 1'b1
    } seq_mode_e;

endpackage

// File: rtl/rail_qual_timer.sv
// Module: rail_qual_timer
// Counts consecutive clock edges at which 'qual' is high.
// 'expired' is high while qual holds in the cycle that would be the
// HOLD_CYCLES-th consecutive qualified edge, or any later one.
// Assumes: HOLD_CYCLES >= 1, and qual is a synchronous level.
module rail_qual_timer #(
    parameter int HOLD_CYCLES = 47_500_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic qual,
    output logic expired
);
    localparam int CW = (HOLD_CYCLES > 1) ? $clog2(HOLD_CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(HOLD_CYCLES - 1);

    logic [CW-1:0] cnt_q;

    // Purpose: saturating count of qualified edges, cleared whenever qual drops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!qual) begin
            cnt_q <= '0;
        end else if (cnt_q != LAST) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Purpose: flag the edge at which the hold time is reached.
    always_comb begin
        expired = qual && (cnt_q == LAST);
    end

endmodule

// File: rtl/rail_seq_core.sv
// Module: rail_seq_core
// Mode register, enable chain and power-good register.
// Assumes: the timer 'expired' strobes come from rail_qual_timer instances
// that are fed by rail_ok[0] (start timer) and by pg_qual (power-good timer).
module rail_seq_core
    import rail_seq_pkg::*;
#(
    parameter int NUM_RAILS = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_RAILS-1:0] rail_ok,
    input  logic                 start_expired,
    input  logic                 pg_expired,
    output logic                 pg_qual,
    output logic [NUM_RAILS-2:0] reg_en,
    output logic                 pwr_good,
    output logic                 mode_sup
);
    localparam int NE = NUM_RAILS - 1;

    seq_mode_e        mode_q;
    logic [NE-1:0]    en_q;
    logic [NE-1:0]    en_chain_d;
    logic             pg_q;

    // Purpose: power-up chain; each enable waits on its predecessor and its own flag.
    generate
        for (genvar k = 0; k < NE; k++) begin : g_chain
            if (k == 0) begin : g_first
                assign en_chain_d[k] = rail_ok[0] && start_expired;
            end else begin : g_next
                assign en_chain_d[k] = rail_ok[0] && en_q[k-1] && rail_ok[k];
            end
        end
    endgenerate

    // Purpose: power-good qualifier; power-up mode also requires every enable on.
    always_comb begin
        pg_qual = (&rail_ok) && ((mode_q == MODE_SUPERVISE) || (&en_q));
    end

    // Purpose: mode latch, enables and power-good, with mode-dependent fault handling.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= MODE_POWERUP;
            en_q   <= '0;
            pg_q   <= 1'b0;
        end else if (mode_q == MODE_SUPERVISE) begin
            if (!rail_ok[0]) begin
                mode_q <= MODE_POWERUP;
                en_q   <= '0;
                pg_q   <= 1'b0;
            end else begin
                pg_q   <= pg_expired;
            end
        end else begin
            en_q <= en_chain_d;
            pg_q <= pg_expired;
            if (pg_expired) begin
                mode_q <= MODE_SUPERVISE;
            end
        end
    end

    assign reg_en   = en_q;
    assign pwr_good = pg_q;
    assign mode_sup = (mode_q == MODE_SUPERVISE);

    AST_PRIMARY_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !rail_ok[0] |=> (reg_en == '0) && !pwr_good);                       // R2

    AST_PG_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_good |-> (&reg_en));                                             // R5

    AST_MODE_ON_PG: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pwr_good) |-> mode_sup);                                       // R5

    AST_SUP_PRIMARY_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_sup && !rail_ok[0]) |=> !mode_sup && (reg_en == '0));          // R6

    AST_SUP_KEEPS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_sup && rail_ok[0]) |=> (&reg_en) && mode_sup);                 // R7

    AST_SUP_PG_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_sup && !(&rail_ok)) |=> !pwr_good);                            // R7

    generate
        for (genvar k = 1; k < NE; k++) begin : g_chain_chk
            AST_CHAIN_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
                (!mode_sup && !reg_en[k-1]) |=> !reg_en[k]);                 // R4
        end
    endgenerate

endmodule

// File: rtl/rail_seq_supervisor.sv
// Module: rail_seq_supervisor (top)
// Sequences NUM_RAILS-1 regulator enables from NUM_RAILS rail-OK flags and
// supervises them after power-good, using two hold-time timers.
// Assumes: rail_ok is already synchronous to clk; HOLD_CYCLES is the hold time
// in clock cycles (the default is 190 ms at 250 MHz).
module rail_seq_supervisor #(
    parameter int NUM_RAILS   = 4,
    parameter int HOLD_CYCLES = 47_500_000
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_RAILS-1:0] rail_ok,
    output logic [NUM_RAILS-2:0] reg_en,
    output logic                 pwr_good,
    output logic                 mode_sup
);
    logic start_expired;
    logic pg_expired;
    logic pg_qual;

    rail_qual_timer #(.HOLD_CYCLES(HOLD_CYCLES)) u_start_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .qual    (rail_ok[0]),
        .expired (start_expired)
    );

    rail_qual_timer #(.HOLD_CYCLES(HOLD_CYCLES)) u_pg_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .qual    (pg_qual),
        .expired (pg_expired)
    );

    rail_seq_core #(.NUM_RAILS(NUM_RAILS)) u_core (
        .clk           (clk),
        .rst_n         (rst_n),
        .rail_ok       (rail_ok),
        .start_expired (start_expired),
        .pg_expired    (pg_expired),
        .pg_qual       (pg_qual),
        .reg_en        (reg_en),
        .pwr_good      (pwr_good),
        .mode_sup      (mode_sup)
    );

    // Independent count of consecutive primary-high edges, used only by the check below.
    localparam int HW = $clog2(HOLD_CYCLES + 1);
    logic [HW-1:0] primary_hold_q;

    // Purpose: saturating run length of rail_ok[0], for the start-delay assertion.
    always_ff @(posedge clk) begin
        if (!rst_n || !rail_ok[0]) begin
            primary_hold_q <= '0;
        end else if (primary_hold_q != HW'(HOLD_CYCLES)) begin
            primary_hold_q <= primary_hold_q + 1'b1;
        end
    end

    AST_START_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(reg_en[0]) |-> (primary_hold_q >= HW'(HOLD_CYCLES)));          // R3

endmodule

// File: tb/tb_rail_seq_supervisor.sv
`timescale 1ns/1ps
module tb_rail_seq_supervisor;
    localparam int NR = 4;
    localparam int D  = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NR-1:0] rail_ok = '0;
    logic [NR-2:0] reg_en;
    logic          pwr_good;
    logic          mode_sup;

    int    n_checks = 0;
    int    n_fails  = 0;
    bit    done     = 1'b0;
    string cur_req  = "R1";

    // Reference model state
    logic [NR-2:0] m_en   = '0;
    logic          m_pg   = 1'b0;
    logic          m_mode = 1'b0;
    int            c_start = 0;
    int            c_pg    = 0;

    rail_seq_supervisor #(.NUM_RAILS(NR), .HOLD_CYCLES(D)) dut (
        .clk(clk), .rst_n(rst_n), .rail_ok(rail_ok),
        .reg_en(reg_en), .pwr_good(pwr_good), .mode_sup(mode_sup)
    );

    always #2 clk = ~clk;

    // Behavioural reference model, advanced at each rising edge.
    always @(posedge clk) begin
        bit q1, e1, qpg, epg;
        logic [NR-2:0] ne;
        if (!rst_n) begin
            m_en = '0; m_pg = 1'b0; m_mode = 1'b0; c_start = 0; c_pg = 0;
        end else begin
            q1  = rail_ok[0];
            e1  = q1 && (c_start >= D - 1);
            qpg = (&rail_ok) && (m_mode || (&m_en));
            epg = qpg && (c_pg >= D - 1);
            c_start = q1  ? c_start + 1 : 0;
            c_pg    = qpg ? c_pg + 1    : 0;
            if (m_mode) begin
                if (!rail_ok[0]) begin
                    m_en = '0; m_pg = 1'b0; m_mode = 1'b0;
                end else begin
                    m_pg = epg;
                end
            end else begin
                ne[0] = rail_ok[0] && e1;
                for (int k = 1; k < NR - 1; k++) ne[k] = rail_ok[0] && m_en[k-1] && rail_ok[k];
                m_en = ne;
                m_pg = epg;
                if (epg) m_mode = 1'b1;
            end
        end
    end

    // Per-cycle comparison against the model, away from the active edge.
    always @(negedge clk) begin
        if (!done) begin
            n_checks++;
            if (reg_en !== m_en || pwr_good !== m_pg || mode_sup !== m_mode) begin
                n_fails++;
                $display("FAIL %s: en=%b pg=%b mode=%b expected en=%b pg=%b mode=%b",
                         cur_req, reg_en, pwr_good, mode_sup, m_en, m_pg, m_mode);
            end
        end
    end

    task automatic expect_now(input string req, input logic [NR-2:0] en,
                              input logic pg, input logic md);
        n_checks++;
        if (reg_en !== en || pwr_good !== pg || mode_sup !== md) begin
            n_fails++;
            $display("FAIL %s: en=%b pg=%b mode=%b expected en=%b pg=%b mode=%b",
                     req, reg_en, pwr_good, mode_sup, en, pg, md);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
            $finish;
        end
    endtask

    initial begin
        #400000;
        n_checks++; n_fails++;
        $display("FAIL watchdog: run did not complete, expected completion");
        finish_run();
    end

    initial begin
        // R1: reset clears everything even with rails high
        cur_req = "R1";
        rail_ok = '1;
        cyc(4);
        expect_now("R1", 3'b000, 1'b0, 1'b0);
        rail_ok = '0;
        rst_n = 1'b1;
        cyc(2);

        // R3: primary high too briefly, then held for the full hold time
        cur_req = "R3";
        rail_ok[0] = 1'b1; cyc(D - 1);
        rail_ok[0] = 1'b0; cyc(1);
        expect_now("R3", 3'b000, 1'b0, 1'b0);
        rail_ok[0] = 1'b1; cyc(D - 1);
        expect_now("R3", 3'b000, 1'b0, 1'b0);
        cyc(1);
        expect_now("R3", 3'b001, 1'b0, 1'b0);

        // R4: chain follows its own flags up and down
        cur_req = "R4";
        rail_ok[1] = 1'b1; cyc(1);
        expect_now("R4", 3'b011, 1'b0, 1'b0);
        rail_ok[2] = 1'b1; cyc(1);
        expect_now("R4", 3'b111, 1'b0, 1'b0);
        rail_ok[1] = 1'b0; cyc(1);
        expect_now("R4", 3'b101, 1'b0, 1'b0);
        cyc(1);
        expect_now("R4", 3'b001, 1'b0, 1'b0);
        rail_ok[1] = 1'b1; cyc(3);

        // R2: primary loss in power-up mode clears the chain
        cur_req = "R2";
        rail_ok[0] = 1'b0; cyc(1);
        expect_now("R2", 3'b000, 1'b0, 1'b0);
        rail_ok[0] = 1'b1; cyc(D + 3);

        // R5: last flag drops one edge short of expiry, then held
        cur_req = "R5";
        rail_ok[3] = 1'b1; cyc(D - 1);
        rail_ok[3] = 1'b0; cyc(1);
        expect_now("R5", 3'b111, 1'b0, 1'b0);
        rail_ok[3] = 1'b1; cyc(D);
        expect_now("R5", 3'b111, 1'b1, 1'b1);

        // R7: downstream loss in supervision keeps enables
        cur_req = "R7";
        rail_ok[2] = 1'b0; cyc(1);
        expect_now("R7", 3'b111, 1'b0, 1'b1);
        cyc(3);

        // R8: recovery needs a full hold; interrupt it once
        cur_req = "R8";
        rail_ok[2] = 1'b1; cyc(D - 2);
        rail_ok[3] = 1'b0; cyc(1);
        rail_ok[3] = 1'b1; cyc(D - 1);
        expect_now("R8", 3'b111, 1'b0, 1'b1);
        cyc(1);
        expect_now("R8", 3'b111, 1'b1, 1'b1);

        // R6: primary and downstream drop together; primary reaction wins
        cur_req = "R6";
        rail_ok[0] = 1'b0; rail_ok[3] = 1'b0; cyc(1);
        expect_now("R6", 3'b000, 1'b0, 1'b0);
        rail_ok[3] = 1'b1; cyc(2);
        rail_ok[0] = 1'b1; cyc(D - 1);
        expect_now("R6", 3'b000, 1'b0, 1'b0);
        cyc(1);
        expect_now("R6", 3'b001, 1'b0, 1'b0);
        cyc(D + 4);
        expect_now("R6", 3'b111, 1'b1, 1'b1);

        // R1: reset in supervision mode returns to power-up
        cur_req = "R1";
        rst_n = 1'b0; cyc(1);
        expect_now("R1", 3'b000, 1'b0, 1'b0);
        rst_n = 1'b1; cyc(2);
        finish_run();
    end

endmodule